// File: doc/BRIEF.md
# Transmit Staging FIFO with DMA Pacing and Refill Interrupt

This block holds outgoing bytes between a host bus and a serial transmit engine. The host pushes bytes one per cycle into a byte-wide FIFO that is 4096 entries deep by default. The serial engine pulls bytes through a request/acknowledge pair. Requests are raised only while software has enabled the transmit DMA path. Software can therefore load a whole message first and then release it, so the engine cannot drain the buffer faster than it is being filled.

A refill interrupt tells the host when the buffer has dropped below half full, so that one block of half the depth can always be written without checking the full flag. The interrupt passes through a master enable. An in-service bit lets an interrupt handler freeze the interrupt line while it runs. Clearing that bit makes the line follow the live condition again in the same cycle. The host can observe an active-low full flag, a half-full flag and an empty flag. Two sticky error bits record a write dropped at full and an acknowledge received while empty.

A single configuration write port carries the control bits. Bit 0 is the DMA enable. Bit 1 is the master interrupt enable. Bit 2 is the in-service lock. Bit 3 is write-one-to-clear for the overflow bit, and bit 4 is write-one-to-clear for the underrun bit. Bits 0 to 2 are loaded on every configuration write.

Top module: `tx_stage_fifo`

## Requirements
- R1: After reset the FIFO is empty. `empty` is 1, `fullN` is 1, `halfFull` is 0, and `irq`, `dmaReq`, `overflow` and `underrun` are all 0. The DMA enable, the master interrupt enable and the in-service bit are all cleared.
- R2: Bytes leave on `dmaData` in the order they were written, and the FIFO holds exactly DEPTH bytes. `dmaData` shows the oldest byte, and an honoured acknowledge removes that byte at the clock edge.
- R3: `fullN` is 0 exactly when DEPTH bytes are held. A host write at that time is dropped, occupancy stays the same, and `overflow` is set the next cycle. `overflow` stays set until a configuration write with bit 3 at 1. If a new overflow occurs in the same cycle as that clear, `overflow` stays set.
- R4: `halfFull` is 1 exactly when occupancy is at least DEPTH/2. `empty` is 1 exactly when occupancy is 0.
- R5: `dmaReq` is 1 exactly when the DMA enable (configuration bit 0) is set and the FIFO is not empty. An acknowledge while the DMA enable is clear removes nothing.
- R6: An acknowledge while the DMA enable is set and the FIFO is empty removes nothing and sets `underrun`. `underrun` stays set until a configuration write with bit 4 at 1, and a new underrun in the same cycle as that clear keeps it set.
- R7: A host write and an honoured acknowledge in the same cycle leave occupancy unchanged and keep byte order.
- R8: With the in-service bit clear, `irq` equals the master enable AND (occupancy < DEPTH/2), following occupancy in the same cycle it changes.
- R9: While the in-service bit (configuration bit 2) is set, `irq` holds the level that the refill condition had in the last cycle before the lock took effect. Once the bit is cleared, `irq` follows R8 again at once.
- R10: While the master interrupt enable (configuration bit 1) is 0, `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host byte write strobe |
| hostWrData | input | DATA_W | Byte written by the host |
| cfgWe | input | 1 | Configuration write strobe |
| cfgData | input | 5 | Control bits: DMA enable, interrupt enable, in-service lock, clear overflow, clear underrun |
| dmaAck | input | 1 | Acknowledge from the serial engine, which consumes `dmaData` |
| dmaReq | output | 1 | Request to the serial engine |
| dmaData | output | DATA_W | Oldest byte held |
| fullN | output | 1 | Active-low full flag |
| halfFull | output | 1 | Occupancy at least DEPTH/2 |
| empty | output | 1 | Occupancy is zero |
| overflow | output | 1 | Sticky: a write was dropped while full |
| underrun | output | 1 | Sticky: an acknowledge arrived while empty |
| irq | output | 1 | Refill interrupt to the host |

## Verification
The bench builds the block with DEPTH = 16 and DATA_W = 8. With that depth, random traffic reaches full, half full and empty many times in a short run. The below-half threshold sits at 8 entries, so the bench crosses it repeatedly while the in-service lock is set and while it is clear. Directed sequences cover overflow at exact capacity, acknowledges while empty, acknowledges while the DMA path is disabled, and the release of the lock while the refill condition still holds.

// File: rtl/txf_pkg.sv
package txf_pkg;
  // positions inside the configuration write word
  localparam int CfgDmaEn  = 0;
  localparam int CfgIrqEn  = 1;
  localparam int CfgInSvc  = 2;
  localparam int CfgClrOvf = 3;
  localparam int CfgClrUnd = 4;
  localparam int CfgW      = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
  } txf_stb_t;
endpackage

// File: rtl/txf_datapath.sv
module txf_datapath #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4096
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  txf_pkg::txf_stb_t    stb,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    headData,
  output logic                 empty,
  output logic                 full,
  output logic                 halfFull,
  output logic                 belowHalf
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CntFull = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CntHalf = CNT_W'(DEPTH / 2);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (stb.push) wrPtr <= wrPtr + 1'b1;
      if (stb.pop)  rdPtr <= rdPtr + 1'b1;
      case ({stb.push, stb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headData  = mem[rdPtr];
  assign empty     = (count == '0);
  assign full      = (count == CntFull);
  assign halfFull  = (count >= CntHalf);
  assign belowHalf = !halfFull;

  // R2: occupancy never exceeds capacity
  a_r2_cap_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CntFull);
  // R4: full and empty are exclusive
  a_r4_flags_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));
  // R7: simultaneous push and pop keep occupancy
  a_r7_balanced: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && stb.pop) |=> $stable(count));
  // R3: no push accepted while full
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !stb.push);
endmodule

// File: rtl/txf_ctrl.sv
module txf_ctrl (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       hostWrEn,
  input  logic                       dmaAck,
  input  logic                       cfgWe,
  input  logic [txf_pkg::CfgW-1:0]   cfgData,
  input  logic                       empty,
  input  logic                       full,
  input  logic                       belowHalf,
  output txf_pkg::txf_stb_t          stb,
  output logic                       dmaReq,
  output logic                       irq,
  output logic                       overflow,
  output logic                       underrun
);
  import txf_pkg::*;

  logic dmaEn, irqEn, inSvc, heldRefill;
  logic ovfHit, undHit, clrOvf, clrUnd;

  assign ovfHit = hostWrEn && full;
  assign undHit = dmaAck && dmaEn && empty;
  assign clrOvf = cfgWe && cfgData[CfgClrOvf];
  assign clrUnd = cfgWe && cfgData[CfgClrUnd];

  always_comb begin
    stb.push = hostWrEn && !full;
    stb.pop  = dmaAck && dmaEn && !empty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaEn      <= 1'b0;
      irqEn      <= 1'b0;
      inSvc      <= 1'b0;
      heldRefill <= 1'b0;
      overflow   <= 1'b0;
      underrun   <= 1'b0;
    end else begin
      if (cfgWe) begin
        dmaEn <= cfgData[CfgDmaEn];
        irqEn <= cfgData[CfgIrqEn];
        inSvc <= cfgData[CfgInSvc];
      end
      if (!inSvc) heldRefill <= belowHalf;
      overflow <= ovfHit || (overflow && !clrOvf);
      underrun <= undHit || (underrun && !clrUnd);
    end
  end

  assign dmaReq = dmaEn && !empty;
  assign irq    = irqEn && (inSvc ? heldRefill : belowHalf);

  // R10: masked interrupt stays low
  a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !irq);
  // R9: line frozen while the lock holds
  a_r9_lock_hold: assert property (@(posedge clk) disable iff (!rstN)
    (inSvc && irqEn && $past(inSvc) && $past(irqEn)) |-> (irq == $past(irq)));
  // R5: no request when nothing is held
  a_r5_req_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> !empty);
  // R3: overflow is sticky unless cleared
  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !clrOvf) |=> overflow);
  // R6: underrun is sticky unless cleared
  a_r6_und_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && !clrUnd) |=> underrun);
endmodule

// File: rtl/tx_stage_fifo.sv
module tx_stage_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4096
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     hostWrEn,
  input  logic [DATA_W-1:0]        hostWrData,
  input  logic                     cfgWe,
  input  logic [txf_pkg::CfgW-1:0] cfgData,
  input  logic                     dmaAck,
  output logic                     dmaReq,
  output logic [DATA_W-1:0]        dmaData,
  output logic                     fullN,
  output logic                     halfFull,
  output logic                     empty,
  output logic                     overflow,
  output logic                     underrun,
  output logic                     irq
);
  txf_pkg::txf_stb_t stb;
  logic full, belowHalf;

  txf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .dmaAck(dmaAck),
    .cfgWe(cfgWe), .cfgData(cfgData), .empty(empty), .full(full),
    .belowHalf(belowHalf), .stb(stb), .dmaReq(dmaReq), .irq(irq),
    .overflow(overflow), .underrun(underrun)
  );

  txf_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(hostWrData),
    .headData(dmaData), .empty(empty), .full(full),
    .halfFull(halfFull), .belowHalf(belowHalf)
  );

  assign fullN = !full;
endmodule

// File: tb/tx_stage_fifo_tb.sv
module tx_stage_fifo_tb;
  localparam int DW = 8;
  localparam int D  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 1'b0;
  logic [DW-1:0] hostWrData = '0;
  logic cfgWe = 1'b0;
  logic [4:0] cfgData = '0;
  logic dmaAck = 1'b0;
  logic dmaReq, fullN, halfFull, empty, overflow, underrun, irq;
  logic [DW-1:0] dmaData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  byte unsigned q[$];
  bit mDma, mIe, mSvc, mHeld, mOvf, mUnd;

  always #4 clk = !clk;

  tx_stage_fifo #(.DATA_W(DW), .DEPTH(D)) u_dut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .cfgWe(cfgWe), .cfgData(cfgData), .dmaAck(dmaAck), .dmaReq(dmaReq),
    .dmaData(dmaData), .fullN(fullN), .halfFull(halfFull), .empty(empty),
    .overflow(overflow), .underrun(underrun), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit expIrq();
    bit refill = (q.size() < D / 2);
    return mIe && (mSvc ? mHeld : refill);
  endfunction

  task automatic checkAll();
    chk("R4 empty", int'(empty), int'(q.size() == 0));
    chk("R3 fullN", int'(fullN), int'(q.size() != D));
    chk("R4 halfFull", int'(halfFull), int'(q.size() >= D / 2));
    chk("R5 dmaReq", int'(dmaReq), int'(mDma && q.size() != 0));
    chk("R3 overflow", int'(overflow), int'(mOvf));
    chk("R6 underrun", int'(underrun), int'(mUnd));
    chk(mSvc ? "R9 irq" : (mIe ? "R8 irq" : "R10 irq"), int'(irq), int'(expIrq()));
    if (q.size() != 0) chk("R2 dmaData", int'(dmaData), int'(q[0]));
  endtask

  // one clock: drive at negedge, model update at posedge, check after
  task automatic step(input bit wr, input byte unsigned wd, input bit ack,
                      input bit cw, input logic [4:0] cd);
    bit isFull, isEmpty, pushOk, popOk;
    @(negedge clk);
    hostWrEn = wr; hostWrData = wd; dmaAck = ack; cfgWe = cw; cfgData = cd;
    isFull = (q.size() == D);
    isEmpty = (q.size() == 0);
    pushOk = wr && !isFull;
    popOk = ack && mDma && !isEmpty;
    @(posedge clk);
    if (!mSvc) mHeld = (q.size() < D / 2);
    if (popOk) void'(q.pop_front());
    if (pushOk) q.push_back(wd);
    mOvf = (wr && isFull) || (mOvf && !(cw && cd[3]));
    mUnd = (ack && mDma && isEmpty) || (mUnd && !(cw && cd[4]));
    if (cw) begin mDma = cd[0]; mIe = cd[1]; mSvc = cd[2]; end
    #2;
    checkAll();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed);
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk("R1 empty", int'(empty), 1);
    chk("R1 fullN", int'(fullN), 1);
    chk("R1 irq", int'(irq), 0);
    chk("R1 dmaReq", int'(dmaReq), 0);
    chk("R1 overflow", int'(overflow), 0);
    chk("R1 underrun", int'(underrun), 0);
    @(negedge clk); rstN = 1'b1;
    step(0, 0, 0, 0, 0);

    // R5: acknowledge with DMA disabled removes nothing
    for (int i = 0; i < 3; i++) step(1, byte'(8'hA0 + i), 0, 0, 0);
    step(0, 0, 1, 0, 0);
    chk("R5 held bytes kept", q.size(), 3);
    // R10: enable irq path with master off, then on
    step(0, 0, 0, 1, 5'b00000);
    step(0, 0, 0, 1, 5'b00010);
    chk("R8 irq below half", int'(irq), 1);
    // fill to capacity, then overflow (R3)
    while (q.size() < D) step(1, byte'($urandom), 0, 0, 0);
    step(1, 8'h55, 0, 0, 0);
    chk("R3 dropped write", int'(overflow), 1);
    step(0, 0, 0, 1, 5'b01010);
    chk("R3 cleared", int'(overflow), 0);
    // R9: lock while above half, then drain below half
    step(0, 0, 0, 1, 5'b00110);
    step(0, 0, 0, 1, 5'b00111);
    while (q.size() > 2) step(0, 0, 1, 0, 0);
    chk("R9 frozen low", int'(irq), 0);
    step(0, 0, 0, 1, 5'b00011);
    chk("R9 release re-evaluates", int'(irq), 1);
    // R7: simultaneous push and pop
    step(1, 8'h77, 1, 0, 0);
    chk("R7 occupancy", q.size(), 2);
    // R6: drain past empty
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    chk("R6 underrun set", int'(underrun), 1);
    step(0, 0, 1, 1, 5'b10011);
    chk("R6 set wins over clear", int'(underrun), 1);
    step(0, 0, 0, 1, 5'b10011);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom % 100);
      bit cw = (r < 4);
      logic [4:0] cd = 5'($urandom);
      step(($urandom % 100) < 55, byte'($urandom), ($urandom % 100) < 50, cw, cd);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule